// File: doc/BRIEF.md
# Multiphase Switching Timebase Generator

This block derives the switching-cycle timing of a regulator with two to six interleaved phases from one fast reference clock. A programmable half-slot length `div_sel` sets how many reference clocks make up half of one phase slot. A switching cycle is therefore `2 × div_sel × Nph` reference clocks long. Each phase slot begins with a one-clock pulse on that phase's bit of a one-hot vector. The current phase index is always visible. A cycle-start pulse marks slot 0, and a voltage-ADC sample strobe fires at the start and at the middle of every slot.

The divider and phase-count inputs are clamped into their legal ranges. They are copied into working registers only at the end of a switching cycle, so a cycle already in progress is never distorted. When spreading is enabled, a pseudo-random offset is added to the clamped divider once per cycle and the sum is clamped again. This moves the switching frequency slightly from cycle to cycle and widens the emission spectrum. The PWM duty-cycle logic and the oscillator are outside this block. Both consume the strobes produced here.

Top module: `mph_timebase`

## Requirements
- R1: With spreading disabled, consecutive `cycle_start_o` pulses are exactly `2 × D × N` reference clocks apart, where D is the effective divider and N the effective phase count.
- R2: `phase_start_o` carries at most one set bit. Bit k pulses for one clock at the start of slot k, slots run 0,1,…,N−1 in rotation, successive pulses are `2 × D` clocks apart, and `phase_idx_o` equals k during each pulse.
- R3: `sample_o` pulses every D clocks. This gives exactly `2 × N` pulses per cycle, and one of them coincides with every phase-start pulse.
- R4: `cycle_start_o` pulses exactly when bit 0 of `phase_start_o` pulses, together with `sample_o`.
- R5: A `div_sel_i` value below 6 is used as 6. Values 6 to 127 are used unchanged.
- R6: An `nph_i` value below 2 is used as 2, and a value above 6 is used as 6.
- R7: Changes to `div_sel_i` or `nph_i` in the middle of a cycle do not alter the remainder of that cycle. They take effect from the next cycle start.
- R8: With `spread_en_i` high, each cycle's divider is the clamped `div_sel_i` plus an offset in −2..+1. The result is clamped to 6..127 and held for the whole cycle. Over a run of cycles the divider varies, and with spreading low it returns to the clamped input.
- R9: While `rst` is high, all strobes are 0 and the configuration is loaded from the inputs. In the first cycle after `rst` falls, `cycle_start_o`, `phase_start_o[0]` and `sample_o` are high and `phase_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_i | input | 7 | Requested half-slot length in reference clocks |
| nph_i | input | 3 | Requested number of phases |
| spread_en_i | input | 1 | Enables pseudo-random divider dithering |
| phase_start_o | output | 6 | One-hot phase-start pulses, bit k for phase k |
| phase_idx_o | output | 3 | Index of the phase slot in progress |
| cycle_start_o | output | 1 | One-clock pulse at the start of each switching cycle |
| sample_o | output | 1 | Voltage-ADC sample strobe, two per phase slot |

## Verification
The cycle boundary is where several functions coincide. In a single clock the cycle-start pulse, the phase-0 pulse and a sample strobe fire together, and the working divider, phase count and dither register reload. The bench provokes this by changing the divider and phase count a few clocks into a cycle. It then judges the result by counting the clocks remaining up to the next cycle start and measuring the length of the cycle that follows. With spreading on, it checks that every slot inside one cycle keeps the same spacing, while the cycle length varies from one cycle to the next within the clamped bounds.

// File: rtl/mph_pkg.sv
package mph_pkg;

    parameter int DIV_W   = 7;
    parameter int DIV_MIN = 6;
    parameter int DIV_MAX = 127;
    parameter int PH_W    = 3;
    parameter int PH_MIN  = 2;
    parameter int PH_MAX  = 6;
    parameter int LFSR_W  = 8;
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;
    parameter int SPR_W   = 2;
    localparam int SUM_W  = DIV_W + 2;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [PH_W-1:0]  ph_t;

    typedef struct packed {
        div_t div;
        ph_t  nph;
    } cfg_t;

    typedef struct packed {
        div_t cnt;
        logic half;
        ph_t  ph;
    } slot_t;

    function automatic div_t clamp_div(input logic signed [SUM_W-1:0] v);
        if (v < SUM_W'(DIV_MIN))
            return DIV_W'(DIV_MIN);
        else if (v > SUM_W'(DIV_MAX))
            return DIV_W'(DIV_MAX);
        else
            return v[DIV_W-1:0];
    endfunction

    function automatic ph_t clamp_nph(input ph_t v);
        if (v < PH_W'(PH_MIN))
            return PH_W'(PH_MIN);
        else if (v > PH_W'(PH_MAX))
            return PH_W'(PH_MAX);
        else
            return v;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

endpackage

// File: rtl/mph_cfg_reg.sv
module mph_cfg_reg
    import mph_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc_end_i,
    input  div_t div_req_i,
    input  ph_t  nph_req_i,
    input  logic spread_en_i,
    output cfg_t cfg_o
);

    logic [LFSR_W-1:0]         lfsr_q;
    cfg_t                      cfg_q;
    div_t                      base_div;
    ph_t                       base_nph;
    logic signed [SPR_W-1:0]   ofs;
    logic signed [SUM_W-1:0]   ofs_ext;
    logic signed [SUM_W-1:0]   sum_s;

    always_comb begin
        base_div = clamp_div($signed({2'b00, div_req_i}));
        base_nph = clamp_nph(nph_req_i);
        ofs      = spread_en_i ? $signed(lfsr_q[SPR_W-1:0]) : '0;
        ofs_ext  = $signed({{(SUM_W-SPR_W){ofs[SPR_W-1]}}, ofs});
        sum_s    = $signed({2'b00, base_div}) + ofs_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.div <= base_div;
            cfg_q.nph <= base_nph;
            lfsr_q    <= LFSR_SEED;
        end else if (cyc_end_i) begin
            cfg_q.div <= clamp_div(sum_s);
            cfg_q.nph <= base_nph;
            lfsr_q    <= lfsr_step(lfsr_q);
        end
    end

    assign cfg_o = cfg_q;

    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.div >= DIV_W'(DIV_MIN)) && (cfg_q.div <= DIV_W'(DIV_MAX)));

    // R6
    nph_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.nph >= PH_W'(PH_MIN)) && (cfg_q.nph <= PH_W'(PH_MAX)));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_end_i |=> $stable(cfg_q));

    // R8
    spread_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end_i && !spread_en_i) |=> (cfg_q.div == $past(base_div)));

    // R8
    spread_win_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end_i && spread_en_i) |=>
            ((int'(cfg_q.div) + 2 >= int'($past(base_div))) &&
             (int'(cfg_q.div) <= int'($past(base_div)) + 1)));

endmodule

// File: rtl/mph_slot_counter.sv
module mph_slot_counter
    import mph_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg_i,
    output slot_t slot_o,
    output logic  cyc_end_o
);

    slot_t slot_q;
    logic  cnt_wrap;
    logic  ph_wrap;

    always_comb begin
        cnt_wrap  = (slot_q.cnt == cfg_i.div - DIV_W'(1));
        ph_wrap   = (slot_q.ph == cfg_i.nph - PH_W'(1));
        cyc_end_o = cnt_wrap && slot_q.half && ph_wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (cnt_wrap) begin
            slot_q.cnt  <= '0;
            slot_q.half <= ~slot_q.half;
            if (slot_q.half)
                slot_q.ph <= ph_wrap ? '0 : slot_q.ph + PH_W'(1);
        end else begin
            slot_q.cnt <= slot_q.cnt + DIV_W'(1);
        end
    end

    assign slot_o = slot_q;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q.cnt < cfg_i.div);

    // R2
    ph_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q.ph < cfg_i.nph);

    // R2
    ph_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_wrap && slot_q.half && !ph_wrap) |=> (slot_q.ph == $past(slot_q.ph) + PH_W'(1)));

endmodule

// File: rtl/mph_strobe_dec.sv
module mph_strobe_dec
    import mph_pkg::*;
#(
    parameter int NPH_OUT = PH_MAX
)(
    input  logic               rst,
    input  slot_t              slot_i,
    output logic [NPH_OUT-1:0] phase_start_o,
    output ph_t                phase_idx_o,
    output logic               cycle_start_o,
    output logic               sample_o
);

    logic tick;
    logic slot_head;

    assign tick      = !rst && (slot_i.cnt == '0);
    assign slot_head = tick && !slot_i.half;

    for (genvar g = 0; g < NPH_OUT; g++) begin : g_phase
        assign phase_start_o[g] = slot_head && (slot_i.ph == PH_W'(g));
    end

    assign sample_o      = tick;
    assign cycle_start_o = slot_head && (slot_i.ph == '0);
    assign phase_idx_o   = slot_i.ph;

endmodule

// File: rtl/mph_timebase.sv
module mph_timebase
    import mph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    div_sel_i,
    input  logic [PH_W-1:0]     nph_i,
    input  logic                spread_en_i,
    output logic [PH_MAX-1:0]   phase_start_o,
    output logic [PH_W-1:0]     phase_idx_o,
    output logic                cycle_start_o,
    output logic                sample_o
);

    cfg_t  cfg;
    slot_t slot;
    logic  cyc_end;

    mph_cfg_reg i_cfg (
        .clk        (clk),
        .rst        (rst),
        .cyc_end_i  (cyc_end),
        .div_req_i  (div_sel_i),
        .nph_req_i  (nph_i),
        .spread_en_i(spread_en_i),
        .cfg_o      (cfg)
    );

    mph_slot_counter i_cnt (
        .clk      (clk),
        .rst      (rst),
        .cfg_i    (cfg),
        .slot_o   (slot),
        .cyc_end_o(cyc_end)
    );

    mph_strobe_dec #(.NPH_OUT(PH_MAX)) i_dec (
        .rst          (rst),
        .slot_i       (slot),
        .phase_start_o(phase_start_o),
        .phase_idx_o  (phase_idx_o),
        .cycle_start_o(cycle_start_o),
        .sample_o     (sample_o)
    );

    // R2
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_start_o));

    // R4
    cyc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> (cycle_start_o && phase_start_o[0] && sample_o));

    // R9
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cycle_start_o && phase_start_o[0] && (phase_idx_o == '0)));

endmodule

// File: tb/test_mph_timebase.sv
module test_mph_timebase;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] div_sel = 7'd8;
    logic [2:0] nph = 3'd2;
    logic       spread = 1'b0;
    logic [5:0] ps;
    logic [2:0] idx;
    logic       cs;
    logic       smp;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    mph_timebase i_mph_timebase (
        .clk          (clk),
        .rst          (rst),
        .div_sel_i    (div_sel),
        .nph_i        (nph),
        .spread_en_i  (spread),
        .phase_start_o(ps),
        .phase_idx_o  (idx),
        .cycle_start_o(cs),
        .sample_o     (smp)
    );

    // {div_sel, nph, expected div, expected nph}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {7'd12,  3'd3, 7'd12,  3'd3},
        {7'd6,   3'd2, 7'd6,   3'd2},
        {7'd20,  3'd6, 7'd20,  3'd6},
        {7'd3,   3'd4, 7'd6,   3'd4},
        {7'd0,   3'd2, 7'd6,   3'd2},
        {7'd9,   3'd1, 7'd9,   3'd2},
        {7'd8,   3'd7, 7'd8,   3'd6},
        {7'd127, 3'd2, 7'd127, 3'd2},
        {7'd10,  3'd0, 7'd10,  3'd2},
        {7'd7,   3'd5, 7'd7,   3'd5}
    };

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cs();
        do @(negedge clk); while (!cs);
    endtask

    // Assumes the current negedge shows a cycle start; returns at the next one.
    task automatic measure(output int period, output int nph_seen, output int samples,
                           output int sp0, output bit uniform, output bit order_ok);
        int t = 0;
        int last = 0;
        int k = 0;
        samples = 1;
        sp0 = 0;
        uniform = 1'b1;
        order_ok = (ps == 6'd1) && (idx == 3'd0) && smp;
        forever begin
            @(negedge clk);
            t++;
            if (cs) break;
            if (smp) samples++;
            if (ps != '0) begin
                k++;
                if (ps != 6'(1 << k) || idx != 3'(k) || !smp) order_ok = 1'b0;
                if (sp0 == 0) sp0 = t - last;
                else if (t - last != sp0) uniform = 1'b0;
                last = t;
            end
        end
        if (t - last != sp0) uniform = 1'b0;
        period = t;
        nph_seen = k + 1;
    endtask

    task automatic spread_run(input int d, input int n, input int lo, input int hi);
        int period, nseen, samples, sp0;
        bit uni, ord, varied;
        @(negedge clk);
        div_sel = 7'(d);
        nph = 3'(n);
        spread = 1'b1;
        wait_cs();
        varied = 1'b0;
        repeat (16) begin
            measure(period, nseen, samples, sp0, uni, ord);
            check_eq("R8", "period multiple of 2N", period % (2 * n), 0);
            check_eq("R8", "dithered divider in window",
                     int'((period / (2 * n) >= lo) && (period / (2 * n) <= hi)), 1);
            check_eq("R8", "slots equal within cycle", int'(uni), 1);
            if (period / (2 * n) != d) varied = 1'b1;
        end
        check_eq("R8", "divider varied", int'(varied), 1);
        @(negedge clk);
        spread = 1'b0;
        wait_cs();
        measure(period, nseen, samples, sp0, uni, ord);
        check_eq("R8", "nominal period after spread off", period, 2 * d * n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired, run hung");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int period, nseen, samples, sp0, t, max_idx;
        bit uni, ord;

        // R9: quiet during reset, cycle start right after release
        repeat (3) begin
            @(negedge clk);
            check_eq("R9", "strobes quiet in reset", int'({ps, cs, smp}), 0);
        end
        rst = 1'b0;
        #1;
        check_eq("R9", "first cycle start", int'({ps, idx, cs, smp}), {6'd1, 3'd0, 1'b1, 1'b1});
        measure(period, nseen, samples, sp0, uni, ord);
        check_eq("R9", "config loaded in reset", period, 32);

        // Vector walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            int d, n, ed, en;
            d  = int'(VEC[i][19:13]);
            n  = int'(VEC[i][12:10]);
            ed = int'(VEC[i][9:3]);
            en = int'(VEC[i][2:0]);
            @(negedge clk);
            div_sel = 7'(d);
            nph = 3'(n);
            wait_cs();
            check_eq("R4", "cycle start with phase0 and sample", int'({ps[0], smp}), 3);
            measure(period, nseen, samples, sp0, uni, ord);
            check_eq("R1", "cycle period", period, 2 * ed * en);
            check_eq("R2", "phase count", nseen, en);
            check_eq("R2", "phase order and index", int'(ord), 1);
            check_eq("R2", "phase spacing", sp0, 2 * ed);
            check_eq("R2", "spacing uniform", int'(uni), 1);
            check_eq("R3", "samples per cycle", samples, 2 * en);
            if (d < 6) check_eq("R5", "low divider clamped", sp0, 12);
            if (n < 2 || n > 6) check_eq("R6", "phase count clamped", nseen, en);
        end

        // R7: mid-cycle change waits for the boundary
        @(negedge clk);
        div_sel = 7'd10;
        nph = 3'd3;
        wait_cs();
        t = 0;
        repeat (5) begin
            @(negedge clk);
            t++;
        end
        div_sel = 7'd20;
        nph = 3'd4;
        max_idx = 0;
        do begin
            @(negedge clk);
            t++;
            if (!cs && int'(idx) > max_idx) max_idx = int'(idx);
        end while (!cs);
        check_eq("R7", "current cycle length kept", t, 60);
        check_eq("R7", "current phase count kept", max_idx, 2);
        measure(period, nseen, samples, sp0, uni, ord);
        check_eq("R7", "new period at next cycle", period, 160);
        check_eq("R7", "new phase count at next cycle", nseen, 4);

        // R8: spreading, including the clamp at both ends
        spread_run(40, 3, 38, 41);
        spread_run(127, 2, 125, 127);
        spread_run(6, 2, 6, 7);

        // R9: reset again mid-run
        @(negedge clk);
        div_sel = 7'd15;
        nph = 3'd2;
        rst = 1'b1;
        @(negedge clk);
        check_eq("R9", "strobes quiet in second reset", int'({ps, cs, smp}), 0);
        rst = 1'b0;
        #1;
        check_eq("R9", "cycle start after second reset", int'({ps, idx, cs, smp}), {6'd1, 3'd0, 1'b1, 1'b1});
        measure(period, nseen, samples, sp0, uni, ord);
        check_eq("R9", "period after second reset", period, 60);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule